// File: doc/BRIEF.md
# Double-Buffered DAC Input Interface

This block is the digital front end of a 16-bit digital-to-analog converter. A host loads a first-rank holding register either one bit at a time over a serial pin or one byte at a time over an 8-bit bus. A level-sensitive load strobe then copies the holding register into a second-rank register, whose value is the converter code. Because of the double buffering, a new word can be staged without disturbing the output, and several converters can be updated at the same moment.

A mode pin sets the role of the bus pins. In serial mode, bus bit 0 carries the serial data and bus bit 1 selects the shift direction. The bit that leaves the holding register is presented on a serial output, so converters can be daisy-chained. A level-sensitive clear forces only the second rank to unipolar or bipolar zero. All pins are asynchronous to the system clock and pass through synchronizer flip-flops first.

Top module: `dbuf_dac_front`

## Requirements
- R1: While reset is low and after it is released, `code_o` is 16'h0000 and `sout_o` is 0. The holding register is also zero.
- R2: In serial mode (`byte_mode_i` = 0) with `bus_i[1]` = 0, each rising edge of `cs_n_i` shifts the holding register left by one place and puts `bus_i[0]` into bit 0.
- R3: In serial mode with `bus_i[1]` = 1, each rising edge of `cs_n_i` shifts the holding register right by one place and puts `bus_i[0]` into bit 15.
- R4: In serial mode, each rising edge of `cs_n_i` puts the bit that leaves the holding register on `sout_o`. That is bit 15 when shifting left and bit 0 when shifting right. `sout_o` holds its value at all other times.
- R5: In byte mode (`byte_mode_i` = 1), a rising edge of `cs_n_i` writes `bus_i[7:0]` into bits 15:8 if `hi_en_i` is 1 and into bits 7:0 if `lo_en_i` is 1. With both set, both halves take the byte. With neither set, nothing is written. The halves may be written in either order.
- R6: In serial mode, `hi_en_i` and `lo_en_i` have no effect on what is loaded into the holding register.
- R7: While `load_i` is high and `clear_i` is low, the second rank follows the holding register. While both are low, `code_o` holds its value.
- R8: While `clear_i` is high, `code_o` is 16'h0000 if `lo_en_i` is 0 and 16'h8000 if `lo_en_i` is 1, in either mode. The holding register is unchanged, so a later load restores the word held before the clear.
- R9: When `clear_i` and `load_i` are high at the same time, the clear value wins.
- R10: A pin change sampled at clock edge k acts on the registers at edge k+2. For a chip-select edge, that change reaches `code_o` at edge k+3 if load is already high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_mode_i | input | 1 | 1 = byte loading, 0 = serial loading |
| bus_i | input | 8 | Byte data. In serial mode, bit 0 is the data bit and bit 1 is the direction |
| cs_n_i | input | 1 | Chip select, acts on its rising edge |
| hi_en_i | input | 1 | Upper-byte enable (byte mode) |
| lo_en_i | input | 1 | Lower-byte enable. Also selects the clear value |
| load_i | input | 1 | Level load strobe into the second rank |
| clear_i | input | 1 | Level clear of the second rank |
| sout_o | output | 1 | Serial output for chaining |
| code_o | output | 16 | Converter code, offset binary |

## Verification
The assertions take for granted two things about the pins. First, the bus, mode and enable pins are steady for several clocks around each chip-select rising edge. Second, the clear level pin is steady while clear is high. This lets the synchronized copies of these pins line up with the detected edge. The stimulus sets data, mode and enables one clock before lowering chip select. It holds chip select low for four clocks and high for five. It changes mode, enables, load and clear only while chip select is idle high.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned WORD_W = 2 * BYTE_W;
    localparam int unsigned SYNC_STAGES = 2;

    typedef enum logic {
        SHIFT_TO_MSB = 1'b0,
        SHIFT_TO_LSB = 1'b1
    } shift_dir_e;

    typedef struct packed {
        logic              cs_n;
        logic              load;
        logic              clear;
        logic              byte_mode;
        logic              hi_en;
        logic              lo_en;
        logic [BYTE_W-1:0] bus;
    } pins_t;

    localparam int unsigned PINS_W = $bits(pins_t);
    localparam logic [PINS_W-1:0] PINS_IDLE = {1'b1, {(PINS_W-1){1'b0}}};
endpackage

// File: rtl/dbuf_sync.sv
module dbuf_sync #(
    parameter int unsigned W       = 4,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= RST_VAL;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= stg_d[i];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dbuf_rank.sv
module dbuf_rank
    import dbuf_pkg::*;
#(
    parameter int unsigned BW = BYTE_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n_s,
    input  logic            byte_mode_s,
    input  logic            hi_en_s,
    input  logic            lo_en_s,
    input  logic [BW-1:0]   bus_s,
    output logic [2*BW-1:0] rank_o,
    output logic            sout_o
);
    localparam int unsigned WW    = 2 * BW;
    localparam int unsigned LANES = 2;

    typedef struct packed {
        logic          cs_prev;
        logic [WW-1:0] rank;
        logic          sout;
    } rank_st_t;

    rank_st_t   d, q;
    logic       stb;
    logic [LANES-1:0] lane_en;
    shift_dir_e dir;

    assign stb     = cs_n_s & ~q.cs_prev;
    assign lane_en = {hi_en_s, lo_en_s};
    assign dir     = shift_dir_e'(bus_s[1]);

    always_comb begin
        d         = q;
        d.cs_prev = cs_n_s;
        if (stb) begin
            if (!byte_mode_s) begin
                if (dir == SHIFT_TO_LSB) begin
                    d.sout = q.rank[0];
                    d.rank = {bus_s[0], q.rank[WW-1:1]};
                end else begin
                    d.sout = q.rank[WW-1];
                    d.rank = {q.rank[WW-2:0], bus_s[0]};
                end
            end else begin
                for (int l = 0; l < LANES; l++) begin
                    if (lane_en[l]) begin
                        d.rank[l*BW +: BW] = bus_s;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cs_prev <= 1'b1;
            q.rank    <= '0;
            q.sout    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign rank_o = q.rank;
    assign sout_o = q.sout;

    // R2
    msb_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !byte_mode_s && !bus_s[1]) |=>
        (rank_o == {$past(rank_o[WW-2:0]), $past(bus_s[0])}));

    // R3
    lsb_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !byte_mode_s && bus_s[1]) |=>
        (rank_o == {$past(bus_s[0]), $past(rank_o[WW-1:1])}));

    // R4
    sout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(sout_o));

    // R5
    byte_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && byte_mode_s && hi_en_s) |=> (rank_o[WW-1:BW] == $past(bus_s)));

    // R5
    rank_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(rank_o));
endmodule

// File: rtl/dbuf_dacreg.sv
module dbuf_dacreg #(
    parameter int unsigned WW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_s,
    input  logic          clear_s,
    input  logic          lo_en_s,
    input  logic [WW-1:0] rank_i,
    output logic [WW-1:0] code_o
);
    localparam logic [WW-1:0] UNI_ZERO = '0;
    localparam logic [WW-1:0] BIP_ZERO = {1'b1, {(WW-1){1'b0}}};

    typedef struct packed {
        logic [WW-1:0] code;
    } dac_st_t;

    dac_st_t d, q;

    always_comb begin
        d = q;
        if (clear_s) begin
            d.code = lo_en_s ? BIP_ZERO : UNI_ZERO;
        end else if (load_s) begin
            d.code = rank_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.code <= '0;
        end else begin
            q <= d;
        end
    end

    assign code_o = q.code;

    // R8
    clr_uni_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_s && !lo_en_s) |=> (code_o == '0));

    // R8
    clr_bip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_s && lo_en_s) |=> (code_o[WW-1] && code_o[WW-2:0] == '0));

    // R9
    clr_over_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_s && load_s) |=> ($countones(code_o) <= 1 && code_o[WW-2:0] == '0));

    // R7
    follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_s && !clear_s) |=> (code_o == $past(rank_i)));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_s && !clear_s) |=> $stable(code_o));
endmodule

// File: rtl/dbuf_dac_front.sv
module dbuf_dac_front
    import dbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_mode_i,
    input  logic [BYTE_W-1:0] bus_i,
    input  logic              cs_n_i,
    input  logic              hi_en_i,
    input  logic              lo_en_i,
    input  logic              load_i,
    input  logic              clear_i,
    output logic              sout_o,
    output logic [WORD_W-1:0] code_o
);
    pins_t raw, syn;
    logic [PINS_W-1:0] raw_vec, syn_vec;
    logic [WORD_W-1:0] rank;

    always_comb begin
        raw.cs_n      = cs_n_i;
        raw.load      = load_i;
        raw.clear     = clear_i;
        raw.byte_mode = byte_mode_i;
        raw.hi_en     = hi_en_i;
        raw.lo_en     = lo_en_i;
        raw.bus       = bus_i;
    end

    assign raw_vec = raw;
    assign syn     = pins_t'(syn_vec);

    dbuf_sync #(
        .W      (PINS_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PINS_IDLE)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (raw_vec),
        .q_o  (syn_vec)
    );

    dbuf_rank #(.BW(BYTE_W)) u_rank (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_s     (syn.cs_n),
        .byte_mode_s(syn.byte_mode),
        .hi_en_s    (syn.hi_en),
        .lo_en_s    (syn.lo_en),
        .bus_s      (syn.bus),
        .rank_o     (rank),
        .sout_o     (sout_o)
    );

    dbuf_dacreg #(.WW(WORD_W)) u_dac (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_s (syn.load),
        .clear_s(syn.clear),
        .lo_en_s(syn.lo_en),
        .rank_i (rank),
        .code_o (code_o)
    );
endmodule

// File: tb/sim_dbuf_dac_front.sv
module sim_dbuf_dac_front;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_mode = 1'b0;
    logic [7:0]  bus = '0;
    logic        cs_n = 1'b1;
    logic        hi_en = 1'b0;
    logic        lo_en = 1'b0;
    logic        load = 1'b0;
    logic        clear = 1'b0;
    logic        sout;
    logic [15:0] code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dbuf_dac_front u0 (
        .clk(clk), .rst_n(rst_n), .byte_mode_i(byte_mode), .bus_i(bus),
        .cs_n_i(cs_n), .hi_en_i(hi_en), .lo_en_i(lo_en), .load_i(load),
        .clear_i(clear), .sout_o(sout), .code_o(code)
    );

    // reference model: pin history of the last three edges
    localparam int CS = 13, LD = 12, CL = 11, MD = 10, HI = 9, LO = 8;
    logic [13:0] h1, h2, h3, cur;
    logic [15:0] m_rank, m_dac, old_rank;
    logic        m_sout;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h1 = 14'h2000; h2 = 14'h2000; h3 = 14'h2000;
            m_rank = '0; m_dac = '0; m_sout = 1'b0;
        end else begin
            cur = {cs_n, load, clear, byte_mode, hi_en, lo_en, bus};
            old_rank = m_rank;
            if (h2[CS] && !h3[CS]) begin
                if (!h2[MD]) begin
                    if (h2[1]) begin
                        m_sout = m_rank[0];
                        m_rank = {h2[0], m_rank[15:1]};
                    end else begin
                        m_sout = m_rank[15];
                        m_rank = {m_rank[14:0], h2[0]};
                    end
                end else begin
                    if (h2[HI]) m_rank[15:8] = h2[7:0];
                    if (h2[LO]) m_rank[7:0]  = h2[7:0];
                end
            end
            if (h2[CL])      m_dac = h2[LO] ? 16'h8000 : 16'h0000;
            else if (h2[LD]) m_dac = old_rank;
            h3 = h2; h2 = h1; h1 = cur;
        end
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // R10: per-clock comparison against the latency model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R10 code", code, m_dac);
            check("R10 sout", {15'b0, sout}, {15'b0, m_sout});
        end
    end

    task automatic finish_run;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    task automatic strobe;
        @(negedge clk) cs_n = 1'b0;
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic shift_word(input logic [15:0] w, input bit lsb, output logic [15:0] outs);
        outs = '0;
        @(negedge clk) begin byte_mode = 1'b0; bus[1] = lsb; end
        for (int i = 0; i < 16; i++) begin
            bus[0] = lsb ? w[i] : w[15-i];
            strobe();
            if (lsb) outs[i] = sout;
            else     outs[15-i] = sout;
        end
    endtask

    task automatic write_byte(input logic [7:0] b, input bit hi, input bit lo);
        @(negedge clk) begin byte_mode = 1'b1; bus = b; hi_en = hi; lo_en = lo; end
        strobe();
        hi_en = 1'b0; lo_en = 1'b0;
    endtask

    task automatic pulse_load;
        @(negedge clk) load = 1'b1;
        repeat (6) @(negedge clk);
        load = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_clear(input bit lvl);
        @(negedge clk) lo_en = lvl;
        @(negedge clk) clear = 1'b1;
        repeat (6) @(negedge clk);
        clear = 1'b0;
        repeat (4) @(negedge clk);
        lo_en = 1'b0;
    endtask

    initial begin
        logic [15:0] outs;
        repeat (3) @(negedge clk);
        check("R1 code in reset", code, 16'h0000);
        check("R1 sout in reset", {15'b0, sout}, 16'h0000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 code after reset", code, 16'h0000);
        check("R1 sout after reset", {15'b0, sout}, 16'h0000);

        // R2: left shift
        shift_word(16'hA5C3, 1'b0, outs);
        check("R4 zeros out of empty register", outs, 16'h0000);
        pulse_load();
        check("R2 serial shift left", code, 16'hA5C3);

        // R4: chained data leaves msb first
        shift_word(16'h3E71, 1'b0, outs);
        check("R4 sout stream left", outs, 16'hA5C3);
        check("R7 hold while load low", code, 16'hA5C3);
        pulse_load();
        check("R7 load copies", code, 16'h3E71);

        // R3: right shift
        shift_word(16'h1234, 1'b1, outs);
        check("R4 sout stream right", outs, 16'h3E71);
        pulse_load();
        check("R3 serial shift right", code, 16'h1234);

        // R6: enables high in serial mode
        @(negedge clk) begin hi_en = 1'b1; lo_en = 1'b1; end
        shift_word(16'hC0DE, 1'b0, outs);
        @(negedge clk) begin hi_en = 1'b0; lo_en = 1'b0; end
        pulse_load();
        check("R6 enables ignored in serial", code, 16'hC0DE);

        // R5: byte mode, low then high
        write_byte(8'hEF, 1'b0, 1'b1);
        write_byte(8'hBE, 1'b1, 1'b0);
        check("R7 hold during byte writes", code, 16'hC0DE);
        pulse_load();
        check("R5 low then high", code, 16'hBEEF);
        write_byte(8'h77, 1'b1, 1'b0);
        write_byte(8'h01, 1'b0, 1'b1);
        pulse_load();
        check("R5 high then low", code, 16'h7701);
        write_byte(8'h3C, 1'b1, 1'b1);
        pulse_load();
        check("R5 both enables", code, 16'h3C3C);
        write_byte(8'hFF, 1'b0, 1'b0);
        pulse_load();
        check("R5 no enable", code, 16'h3C3C);

        // R8: clear values and restore
        pulse_clear(1'b0);
        check("R8 unipolar clear", code, 16'h0000);
        pulse_load();
        check("R8 restore after clear", code, 16'h3C3C);
        pulse_clear(1'b1);
        check("R8 bipolar clear byte mode", code, 16'h8000);
        @(negedge clk) byte_mode = 1'b0;
        pulse_load();
        pulse_clear(1'b1);
        check("R8 bipolar clear serial mode", code, 16'h8000);

        // R9: clear beats load
        @(negedge clk) begin lo_en = 1'b0; load = 1'b1; clear = 1'b1; end
        repeat (5) @(negedge clk);
        check("R9 clear over load", code, 16'h0000);
        clear = 1'b0;
        repeat (5) @(negedge clk);
        check("R9 load resumes after clear", code, 16'h3C3C);
        load = 1'b0;
        repeat (4) @(negedge clk);

        finish_run();
    end
endmodule